// File: doc/BRIEF.md
# Word-Aligned Next-PC Unit

This block holds the program counter of a simple processor that runs one instruction per clock. Instructions are four bytes wide and always sit on a four-byte boundary, so the block stores only the word address, which is the byte address without its two low bits. Those two low bits always read as zero. On every clock edge the block loads the next word address. It picks one of three candidates: the following word, a branch target relative to the following word, or an absolute jump target.

The decoder supplies three controls: jump, branch-if-equal and branch-if-not-equal. The ALU supplies its zero flag. The instruction word supplies a 16-bit branch offset and a 26-bit jump field. The block drives the full byte address to instruction fetch. It also drives the byte address of the following word, which the rest of the pipeline can use. The PC is updated on the same edge as the register file and the data memory. A synchronous, active-high reset returns it to a reset word address, which is zero by default.

Top module: `word_pc_sequencer`

## Requirements
- R1: Bits [1:0] of `pcOut` and of `pcIncOut` are always 0.
- R2: When `rst` is 1 at a rising edge, `pcOut` becomes 0 after that edge. This holds whatever the other inputs are, a jump included.
- R3: With no taken branch and no jump, `pcOut` advances by 4 at each edge. `pcIncOut` always equals `pcOut + 4`, modulo 2^32.
- R4: With `isBrEq`=1 and `aluZero`=1, the next `pcOut` is `pcOut + 4 + 4*sext(brImm)`, where `brImm` is a signed 16-bit word offset.
- R5: With `isBrNe`=1 and `aluZero`=0, the next `pcOut` is formed the same way as in R4.
- R6: A branch control whose condition fails (`isBrEq` with `aluZero`=0, or `isBrNe` with `aluZero`=1) gives the sequential result of R3.
- R7: With `isJump`=1, the next `pcOut` has the following fields:
  - bits [31:28] are copied from `pcIncOut[31:28]`, not from `pcOut`;
  - bits [27:2] are `jmpImm`;
  - bits [1:0] are 0.
- R8: When `isJump`=1, any branch condition is ignored and the jump target is taken.
- R9: Sequential and branch arithmetic wrap modulo 2^32, with no overflow flag. Stepping from 0xFFFFFFFC gives 0. From 0, an offset of -2 gives 0xFFFFFFFC.
- R10: The full range of the offset is sign-extended correctly, from 0x7FFF (+32767 words) to 0x8000 (-32768 words).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| isJump | input | 1 | Current instruction is an absolute jump |
| isBrEq | input | 1 | Current instruction is branch-if-equal |
| isBrNe | input | 1 | Current instruction is branch-if-not-equal |
| aluZero | input | 1 | ALU zero flag from the operand compare |
| brImm | input | 16 | Signed word offset for branches |
| jmpImm | input | 26 | Word-address field for jumps |
| pcOut | output | 32 | Current byte address for instruction fetch |
| pcIncOut | output | 32 | Byte address of the following word |

## Verification
The bench steers the PC across the boundaries where a wrong design would show itself:
- **Jump upper bits.** A jump is issued from word 0x03FFFFFF. A design that took the upper nibble from the current PC instead of the incremented one would land in region 0 instead of region 1.
- **Wrap.** A branch of -2 from address 0 checks the wrap downward, and a step from 0xFFFFFFFC checks the wrap upward. An implementation that sign-extended to the wrong width, or that saturated, would not reach the top word or return to 0.
- **Offset range.** The extreme offsets 0x7FFF and 0x8000 catch an off-by-one in the sign-extension point.
- **Control combinations.** All sixteen combinations of the three controls and the zero flag are swept with varied offsets. This exposes an inverted not-equal condition, and a branch that overrides a jump.
- **Reset.** A reset asserted together with a jump must still give address 0.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  // Strobes from the control module into the datapath.
  typedef struct packed {
    logic takeJump;    // load the absolute jump target
    logic takeBranch;  // load the PC-relative branch target
  } pcStrobe_t;
endpackage

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
  import wpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       isJump,
  input  logic       isBrEq,
  input  logic       isBrNe,
  input  logic       aluZero,
  output pcStrobe_t  strobe
);
  logic eqHit;
  logic neHit;

  always_comb begin
    eqHit = isBrEq & aluZero;
    neHit = isBrNe & ~aluZero;
    strobe.takeJump   = isJump;
    // A jump always wins over a branch.
    strobe.takeBranch = (eqHit | neHit) & ~isJump;
  end

  // R8: when a jump is requested, no branch strobe is raised.
  p_jump_wins_r8 : assert property (@(posedge clk) disable iff (rst)
    isJump |-> !strobe.takeBranch);

  // R5: a not-equal branch with a clear zero flag is taken when no jump is present.
  p_ne_taken_r5 : assert property (@(posedge clk) disable iff (rst)
    (isBrNe && !aluZero && !isJump) |-> strobe.takeBranch);

  // R6: a branch whose condition fails never raises a strobe.
  p_fail_seq_r6 : assert property (@(posedge clk) disable iff (rst)
    (!isJump && !(isBrEq && aluZero) && !(isBrNe && !aluZero)) |-> !strobe.takeBranch && !strobe.takeJump);
endmodule

// File: rtl/wpc_dpath.sv
module wpc_dpath
  import wpc_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          ALIGN_BITS = 2,
  parameter int          BIMM_W     = 16,
  parameter int          JIMM_W     = 26,
  parameter int unsigned RESET_WORD = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  pcStrobe_t         strobe,
  input  logic [BIMM_W-1:0] brImm,
  input  logic [JIMM_W-1:0] jmpImm,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] pcIncOut
);
  localparam int PW   = ADDR_W - ALIGN_BITS;  // stored word-address width
  localparam int HI_W = PW - JIMM_W;          // upper bits kept on a jump
  localparam int SX_W = PW - BIMM_W;          // sign-extension width

  logic [PW-1:0] pcWord;
  logic [PW-1:0] incWord;
  logic [PW-1:0] offExt;
  logic [PW-1:0] brWord;
  logic [PW-1:0] jmpWord;
  logic [PW-1:0] nextWord;
  logic          rstQ;

  always_comb begin
    incWord  = pcWord + PW'(1);
    offExt   = {{SX_W{brImm[BIMM_W-1]}}, brImm};
    brWord   = incWord + offExt;
    jmpWord  = {incWord[PW-1 -: HI_W], jmpImm};
    nextWord = incWord;
    if (strobe.takeJump)        nextWord = jmpWord;
    else if (strobe.takeBranch) nextWord = brWord;
  end

  always_ff @(posedge clk) begin
    if (rst) pcWord <= PW'(RESET_WORD);
    else     pcWord <= nextWord;
    rstQ <= rst;
  end

  assign pcOut    = {pcWord,  {ALIGN_BITS{1'b0}}};
  assign pcIncOut = {incWord, {ALIGN_BITS{1'b0}}};

  // R2: the cycle after a reset edge shows the reset word.
  p_reset_word_r2 : assert property (@(posedge clk)
    rstQ |-> pcWord == PW'(RESET_WORD));

  // R3: with no strobe, the word address advances by one.
  p_seq_step_r3 : assert property (@(posedge clk) disable iff (rst)
    (!strobe.takeJump && !strobe.takeBranch) |=> pcWord == $past(pcWord) + PW'(1));

  // R4: a branch strobe moves the PC by one word plus the signed offset.
  p_branch_r4 : assert property (@(posedge clk) disable iff (rst)
    strobe.takeBranch |=> pcWord == $past(pcWord) + PW'(1) + $past(offExt));

  // R7: a jump keeps the upper bits of the incremented word and loads the field.
  p_jump_r7 : assert property (@(posedge clk) disable iff (rst)
    strobe.takeJump |=> (pcWord[JIMM_W-1:0] == $past(jmpImm)) &&
                        (pcWord[PW-1 -: HI_W] == $past(incWord[PW-1 -: HI_W])));
endmodule

// File: rtl/word_pc_sequencer.sv
module word_pc_sequencer
  import wpc_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          ALIGN_BITS = 2,
  parameter int          BIMM_W     = 16,
  parameter int          JIMM_W     = 26,
  parameter int unsigned RESET_WORD = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              isJump,
  input  logic              isBrEq,
  input  logic              isBrNe,
  input  logic              aluZero,
  input  logic [BIMM_W-1:0] brImm,
  input  logic [JIMM_W-1:0] jmpImm,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] pcIncOut
);
  pcStrobe_t strobe;

  wpc_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .isJump  (isJump),
    .isBrEq  (isBrEq),
    .isBrNe  (isBrNe),
    .aluZero (aluZero),
    .strobe  (strobe)
  );

  wpc_dpath #(
    .ADDR_W     (ADDR_W),
    .ALIGN_BITS (ALIGN_BITS),
    .BIMM_W     (BIMM_W),
    .JIMM_W     (JIMM_W),
    .RESET_WORD (RESET_WORD)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .brImm    (brImm),
    .jmpImm   (jmpImm),
    .pcOut    (pcOut),
    .pcIncOut (pcIncOut)
  );
endmodule

// File: tb/test_word_pc_sequencer.sv
module test_word_pc_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        isJump = 1'b0, isBrEq = 1'b0, isBrNe = 1'b0, aluZero = 1'b0;
  logic [15:0] brImm = '0;
  logic [25:0] jmpImm = '0;
  logic [31:0] pcOut, pcIncOut;

  int          checks = 0;
  int          errors = 0;
  logic [29:0] mWord = '0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  word_pc_sequencer i_word_pc_sequencer (
    .clk(clk), .rst(rst), .isJump(isJump), .isBrEq(isBrEq), .isBrNe(isBrNe),
    .aluZero(aluZero), .brImm(brImm), .jmpImm(jmpImm),
    .pcOut(pcOut), .pcIncOut(pcIncOut)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected next word address, computed arithmetically from the requirements.
  function automatic logic [29:0] predict(input logic r, input logic j, input logic eq,
                                          input logic ne, input logic z, input logic [29:0] w,
                                          input logic [15:0] bi, input logic [25:0] ji);
    logic [29:0] inc;
    logic [29:0] off;
    inc = w + 30'd1;
    off = 30'($signed(bi));
    if (r) return 30'd0;
    if (j) return ((inc >> 26) << 26) | 30'(ji);
    if ((eq && z) || (ne && !z)) return inc + off;
    return inc;
  endfunction

  task automatic step(input string req, input logic r, input logic j, input logic eq,
                      input logic ne, input logic z, input logic [15:0] bi,
                      input logic [25:0] ji);
    logic [29:0] exp;
    rst = r; isJump = j; isBrEq = eq; isBrNe = ne; aluZero = z;
    brImm = bi; jmpImm = ji;
    exp = predict(r, j, eq, ne, z, mWord, bi, ji);
    @(posedge clk);
    #1;
    mWord = exp;
    chk(req, "pcOut", pcOut, {exp, 2'b00});
    chk("R3", "pcIncOut", pcIncOut, {exp, 2'b00} + 32'd4);
    chk("R1", "low bits", {30'd0, pcOut[1:0] | pcIncOut[1:0]}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(posedge clk);
    #1;
    chk("R2", "reset pc", pcOut, 32'd0);
    mWord = '0;

    // R3: plain sequential flow.
    for (int i = 0; i < 5; i++) step("R3", 0, 0, 0, 0, 0, 16'h0000, 26'd0);
    // R4 and R5: taken branches, forward and backward.
    step("R4", 0, 0, 1, 0, 1, 16'h0005, 26'd0);
    step("R5", 0, 0, 0, 1, 0, 16'hFFFD, 26'd0);
    // R6: branch conditions that fail.
    step("R6", 0, 0, 1, 0, 0, 16'h0040, 26'd0);
    step("R6", 0, 0, 0, 1, 1, 16'h0040, 26'd0);
    // R8: a jump beats a satisfied branch.
    step("R8", 0, 1, 1, 0, 1, 16'h0100, 26'h0000ABC);
    // R7: jump to the last word of region 0, then jump again from there.
    step("R7", 0, 1, 0, 0, 0, 16'h0000, 26'h3FFFFFF);
    chk("R7", "region end", pcOut, 32'h0FFFFFFC);
    step("R7", 0, 1, 0, 0, 0, 16'h0000, 26'h0000123);
    chk("R7", "upper from inc", pcOut, 32'h1000048C);
    // R2: reset wins over a jump in the same cycle.
    step("R2", 1, 1, 0, 0, 0, 16'h0000, 26'h1234567);
    chk("R2", "reset over jump", pcOut, 32'd0);
    // R9: wrap downward and upward.
    step("R9", 0, 0, 1, 0, 1, 16'hFFFE, 26'd0);
    chk("R9", "wrap down", pcOut, 32'hFFFFFFFC);
    step("R9", 0, 0, 0, 0, 0, 16'h0000, 26'd0);
    chk("R9", "wrap up", pcOut, 32'd0);
    // R10: offset extremes.
    step("R10", 0, 0, 1, 0, 1, 16'h7FFF, 26'd0);
    chk("R10", "max fwd", pcOut, 32'h00020000);
    step("R10", 0, 0, 0, 1, 0, 16'h8000, 26'd0);
    chk("R10", "max back", pcOut, 32'h00000004);

    // Sweep of every control combination with varied offsets and jump fields (R4, R5, R6, R7, R8).
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 12; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step("R4", 0, c[3], c[2], c[1], c[0], lfsr, {lfsr[9:0], lfsr});
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule